// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block keeps dynamic or pseudo-static memory alive. It asks a bus arbiter for a dummy memory read at a fixed rate and supplies the address that read must use. A down-counter programmed with an interval value sets how many clocks pass between requests. A free-running row counter walks through 4096 word rows, one row per granted refresh. A programmable base field supplies the upper address bits, so the 8-Kbyte refresh window can be placed on any aligned 8-Kbyte region of a 1-Mbyte space.

Software programs the block through a small write port. The port has three targets: the interval, the base, and a control word that holds the enable bit. The arbiter sees a level request. It grants the request by raising an acknowledge for one clock while the request is high. The refresh address is valid throughout that clock. The bus cycle itself and the memory are outside this block.

Top module: `rfsh_ctrl_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rf_req is 0, rf_addr is 0, the block is disabled, the row counter is 0 and the base field is 0.
- R2: With interval value N enabled and every request acknowledged in the clock after it appears, rf_req rises every N+1 clocks. The first rise comes N+1 clock edges after the edge that sets the enable bit.
- R3: rf_addr bit 0 is 0, bits 12..1 carry the row counter, and bits 19..13 carry the base field written through the port.
- R4: The row counter advances by one on each clock edge where rf_req and rf_ack are both high, and only then. It wraps from 4095 to 0.
- R5: Once raised, rf_req stays high until a clock edge where rf_ack is high. An rf_ack given while rf_req is low has no effect.
- R6: Expiries that occur while a request is still pending merge into that one request. A single acknowledge clears it and the row advances by exactly one.
- R7: While the enable bit is 0, no new request is raised and the interval counter is held at the programmed value.
- R8: A newly written interval is used from the next reload onward. The count already running completes with the old value.
- R9: A write with cfg_we high takes effect at the clock edge. The targets are: cfg_sel 0 writes the interval (cfg_wdata bits 8..0), cfg_sel 1 writes the base (bits 6..0), and cfg_sel 2 writes the enable bit (bit 0). cfg_sel 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 interval, 1 base, 2 control, 3 reserved |
| cfg_wdata | input | 9 | Write data |
| rf_req | output | 1 | Refresh request to the bus arbiter |
| rf_ack | input | 1 | Grant from the arbiter; completes the refresh at the clock edge |
| rf_addr | output | 20 | Byte address of the refresh read |

## Verification
Several corner cases are targeted, each tied to the failure it would expose:
- Interval changed mid-count: the bench writes a new value just after a reload and expects one more gap at the old length. A design that reloads at once would shorten that gap.
- Acknowledge held off across several expiries: a design that counts or queues expiries would raise a second request right after the single grant. A design that lets the grant advance the row twice would also be caught.
- Acknowledge pulses while no request is pending: a design that steps on acknowledge alone would shift the row.
- Re-enable after a disabled stretch: this catches a counter that kept running while disabled.
- Reserved write target: this catches a decoder that aliases it onto a real register.
- A long run at interval 0 takes the row through 4095 to 0.

// File: rtl/rfsh_pkg.sv
// Shared definitions for the refresh request controller.
package rfsh_pkg;
    // Write-port targets; the code values are part of the programming model.
    typedef enum logic [1:0] {
        CFG_INTERVAL = 2'd0,
        CFG_BASE     = 2'd1,
        CFG_CONTROL  = 2'd2,
        CFG_RESERVED = 2'd3
    } cfg_target_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
// Interval down-counter.
// Counts from the reload value to zero, then reloads. The expire output is
// high for the one clock in which the count is zero, so the period is
// reload+1 clocks. Assumes reload_val may change at any time; it is sampled
// only when the counter reloads or while run is low (held at reload value).
module rfsh_interval_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] reload_val,
    output logic         expire
);
    logic [W-1:0] count_q;

    // Count down while running, reload at zero, hold at reload when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run || count_q == '0) begin
            count_q <= reload_val;
        end else begin
            count_q <= count_q - 1'b1;
        end
    end

    // Expiry flag for the zero clock of a running count.
    always_comb begin
        expire = run && (count_q == '0);
    end
endmodule

// File: rtl/rfsh_row_counter.sv
// Refresh row counter.
// Steps by one on each completed refresh and wraps at its width.
// Assumes step is high for exactly one clock per granted refresh.
module rfsh_row_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] row
);
    // Advance the row after each granted refresh; natural wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_req_tracker.sv
// Pending-request flag.
// Set by an expiry, cleared by a grant. Any number of expiries before a grant
// collapse into one request. An expiry in the same clock as a grant raises a
// fresh request. Assumes the grant is only meaningful while the flag is set.
module rfsh_req_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic grant,
    output logic req
);
    // Hold the request until granted; a new expiry re-arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= (req && !grant) || set_req;
        end
    end
endmodule

// File: rtl/rfsh_ctrl_top.sv
// Refresh request controller top.
// Holds the interval, base and enable registers. It ties together the
// interval timer, the pending-request flag and the row counter, and forms
// the refresh byte address {base, row, 0}. Assumes the arbiter raises rf_ack
// for one clock per refresh while rf_req is high.
module rfsh_ctrl_top #(
    parameter  int INTV_W = 9,
    parameter  int ROW_W  = 12,
    parameter  int BASE_W = 7,
    localparam int DATA_W = (INTV_W > BASE_W) ? INTV_W : BASE_W,
    localparam int ADDR_W = 1 + ROW_W + BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              rf_req,
    input  logic              rf_ack,
    output logic [ADDR_W-1:0] rf_addr
);
    import rfsh_pkg::*;

    localparam logic [INTV_W-1:0] INTV_RESET = '1;

    logic [INTV_W-1:0] intv_q;
    logic [BASE_W-1:0] base_q;
    logic              en_q;
    logic              expire;
    logic              grant;
    logic [ROW_W-1:0]  row;
    cfg_target_e       target;

    // Map the raw select lines onto the write targets.
    always_comb begin
        target = cfg_target_e'(cfg_sel);
    end

    // Register write port; the reserved target is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_q <= INTV_RESET;
            base_q <= '0;
            en_q   <= 1'b0;
        end else if (cfg_we) begin
            case (target)
                CFG_INTERVAL: intv_q <= cfg_wdata[INTV_W-1:0];
                CFG_BASE:     base_q <= cfg_wdata[BASE_W-1:0];
                CFG_CONTROL:  en_q   <= cfg_wdata[0];
                default:      ;
            endcase
        end
    end

    rfsh_interval_timer #(.W(INTV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en_q),
        .reload_val (intv_q),
        .expire     (expire)
    );

    rfsh_req_tracker u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (expire),
        .grant   (grant),
        .req     (rf_req)
    );

    // A refresh completes only when a request is actually pending.
    always_comb begin
        grant = rf_req && rf_ack;
    end

    rfsh_row_counter #(.W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (grant),
        .row   (row)
    );

    // Refresh byte address: base on top, row in the middle, word aligned.
    always_comb begin
        rf_addr = {base_q, row, 1'b0};
    end
endmodule

// File: rtl/rfsh_ctrl_sva.sv
// Checker for the refresh request controller, bound into the top.
module rfsh_ctrl_sva #(
    parameter  int INTV_W = 9,
    parameter  int ROW_W  = 12,
    parameter  int BASE_W = 7,
    localparam int DATA_W = (INTV_W > BASE_W) ? INTV_W : BASE_W,
    localparam int ADDR_W = 1 + ROW_W + BASE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              rf_req,
    input logic              rf_ack,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              en
);
    // R5: a request is never withdrawn without a grant.
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_ack) |=> rf_req);

    // R4: a grant moves the row field forward by one, with wrap.
    a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_ack) |=>
            (rf_addr[ROW_W:1] == ROW_W'($past(rf_addr[ROW_W:1]) + 1'b1)));

    // R4: without a grant the row field does not move.
    a_r4_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_req && rf_ack) |=> $stable(rf_addr[ROW_W:1]));

    // R3: a base write appears in the upper address bits.
    a_r3_base_field: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd1) |=>
            (rf_addr[ADDR_W-1:ROW_W+1] == $past(cfg_wdata[BASE_W-1:0])));

    // R7: when disabled and idle, no request appears.
    a_r7_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !rf_req) |=> !rf_req);
endmodule

bind rfsh_ctrl_top rfsh_ctrl_sva #(
    .INTV_W (INTV_W),
    .ROW_W  (ROW_W),
    .BASE_W (BASE_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .rf_req    (rf_req),
    .rf_ack    (rf_ack),
    .rf_addr   (rf_addr),
    .en        (en_q)
);

// File: tb/tb_rfsh_ctrl_top.sv
module tb_rfsh_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [8:0]  cfg_wdata = '0;
    logic        rf_req;
    logic        rf_ack = 1'b0;
    logic [19:0] rf_addr;

    rfsh_ctrl_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rf_req    (rf_req),
        .rf_ack    (rf_ack),
        .rf_addr   (rf_addr)
    );

    always #10 clk = ~clk;

    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    int          budget = 0;
    bit          force_ack = 1'b0;
    bit          done = 1'b0;
    int          exp_row = 0;
    logic [6:0]  exp_base = '0;
    logic [19:0] exp_q[$];
    logic        give;
    logic [19:0] item;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cyc > 30000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog", "run did not finish", cyc, 30000);
            report();
        end
    end

    // Scoreboard monitor and acknowledger: grants pending requests while the
    // budget allows, pops one expected address per grant and compares it.
    always @(negedge clk) begin
        if (!rst_n) begin
            rf_ack = 1'b0;
        end else begin
            give = (rf_req && budget > 0) || force_ack;
            rf_ack = give;
            if (rf_req && give) begin
                if (budget > 0) budget--;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected refresh grant", rf_addr, 0);
                end else begin
                    item = exp_q.pop_front();
                    check(rf_addr == item, "R3", "refresh address", rf_addr, item);
                end
            end
        end
    end

    // Driver: queue expected addresses and allow that many grants.
    task automatic grant_n(input int n);
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({exp_base, exp_row[11:0], 1'b0});
            exp_row = (exp_row + 1) % 4096;
        end
        budget = budget + n;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [8:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_rise(output int t);
        logic prev;
        prev = rf_req;
        forever begin
            @(negedge clk);
            if (!prev && rf_req) break;
            prev = rf_req;
        end
        t = cyc;
    endtask

    initial begin
        int t0, t1, t2, t3;
        bit rose;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(rf_req == 1'b0, "R1", "req after reset", rf_req, 0);
        check(rf_addr == 20'd0, "R1", "addr after reset", rf_addr, 0);

        // R7 and R9: interval written but block disabled -> no requests.
        cfg_write(2'd0, 9'd5);
        rose = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (rf_req) rose = 1'b1;
        end
        check(!rose, "R7", "request while disabled", rose, 0);

        // R2: first request N+1 after enable, then every N+1 clocks.
        grant_n(4);
        cfg_write(2'd2, 9'd1);
        t0 = cyc;
        wait_rise(t1);
        check(t1 - t0 == 6, "R2", "first request delay", t1 - t0, 6);
        for (int k = 0; k < 3; k++) begin
            wait_rise(t2);
            check(t2 - t1 == 6, "R2", "request period", t2 - t1, 6);
            t1 = t2;
        end

        // R3 and R9: new base shows in the upper address bits.
        cfg_write(2'd1, 9'h055);
        exp_base = 7'h55;
        grant_n(2);
        wait_rise(t1);
        wait_rise(t1);
        @(negedge clk);
        @(negedge clk);
        check(rf_addr == {7'h55, 12'd6, 1'b0}, "R3", "addr after base write",
              rf_addr, {7'h55, 12'd6, 1'b0});

        // R8: interval written mid-count applies from the next reload.
        grant_n(3);
        wait_rise(t1);
        cfg_write(2'd0, 9'd2);
        wait_rise(t2);
        check(t2 - t1 == 6, "R8", "gap with old interval", t2 - t1, 6);
        wait_rise(t3);
        check(t3 - t2 == 3, "R8", "gap with new interval", t3 - t2, 3);

        // R6 and R5: hold the grant across several expiries.
        wait_rise(t1);
        rose = 1'b1;
        repeat (9) begin
            @(negedge clk);
            if (!rf_req) rose = 1'b0;
        end
        check(rose, "R5", "request held without grant", rose, 1);
        grant_n(1);
        @(negedge clk);
        @(negedge clk);
        check(rf_req == 1'b0, "R6", "single grant clears merged request", rf_req, 0);
        check(rf_addr[12:1] == 12'(exp_row), "R6", "row advanced once",
              rf_addr[12:1], exp_row);
        @(negedge clk);
        check(rf_req == 1'b1, "R6", "next expiry on schedule", rf_req, 1);

        // R7: disable, drain the pending request, then stay quiet.
        cfg_write(2'd2, 9'd0);
        if (rf_req) begin
            grant_n(1);
            while (budget != 0) @(posedge clk);
        end
        rose = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (rf_req) rose = 1'b1;
        end
        check(!rose, "R7", "no request after disable", rose, 0);

        // R5: acknowledge with no request pending has no effect.
        @(posedge clk);
        force_ack = 1'b1;
        repeat (3) @(posedge clk);
        force_ack = 1'b0;
        @(negedge clk);
        check(rf_addr == {exp_base, exp_row[11:0], 1'b0}, "R5",
              "addr after stray ack", rf_addr, {exp_base, exp_row[11:0], 1'b0});

        // R7: counter held at reload while disabled -> exact first delay.
        cfg_write(2'd0, 9'd3);
        grant_n(1);
        cfg_write(2'd2, 9'd1);
        t0 = cyc;
        wait_rise(t1);
        check(t1 - t0 == 4, "R7", "first request after re-enable", t1 - t0, 4);

        // R9: reserved target write changes nothing.
        grant_n(2);
        cfg_write(2'd3, 9'd1);
        wait_rise(t1);
        wait_rise(t2);
        check(t2 - t1 == 4, "R9", "period after reserved write", t2 - t1, 4);

        // R4: run the row through its wrap at interval 0.
        cfg_write(2'd0, 9'd0);
        grant_n(4096 - exp_row + 4);
        while (budget != 0) @(posedge clk);
        @(negedge clk);
        check(rf_addr[12:1] == 12'd4, "R4", "row after wrap", rf_addr[12:1], 4);
        check(exp_q.size() == 0, "R4", "expected grants left", exp_q.size(), 0);

        done = 1'b1;
        report();
    end
endmodule